// File: doc/BRIEF.md
# Packed Vertex Attribute Assembler

This block sits on the register-write path of a vertex front end. It takes a stream of 32-bit writes. Each write is either a write to the target-index register or a data word. The block unpacks every group of three data words into one attribute of four 24-bit floating-point components. The components are carried as raw bits, and no arithmetic is done on them.

The target index decides where each finished attribute goes:

- **Index 0 to 11:** the attribute is written into one slot of a fixed-attribute bank, and the index then steps to the next slot.
- **Index 12 to 14:** nothing is stored, and a one-cycle invalid-write flag is raised.
- **Index 15:** the attribute feeds the immediate-mode vertex path. That path builds vertices from a configured number of attributes each. When three vertices are held, it offers a triangle on a valid/ready handshake. After the triangle is accepted, it keeps or drops vertices according to the primitive type.

Writes arrive on a valid/ready handshake. While a triangle waits to be accepted, the write port is closed.

Top module: `vattr_assembler`

## Requirements
- R1: After reset, `wr_ready` is 1, and `tri_valid`, `fix_we`, `invalid_wr` and `state_err` are all 0. The target index is 0.
- R2: A write with `wr_is_index`=1 loads the target index from `wr_data[3:0]` and sets the data-word count back to zero. Any partly collected attribute is dropped.
- R3: The third accepted data word completes an attribute. Words w0, w1 and w2 are numbered in arrival order, and the attribute is laid out with component k at bits [24k+23:24k]:
  - component 0 = w2[23:0]
  - component 1 = {w1[15:0], w2[31:24]}
  - component 2 = {w0[7:0], w1[31:16]}
  - component 3 = w0[31:8]
- R4: With a target index below 12, `fix_we` pulses for one cycle in the cycle after the third word is accepted. `fix_slot` carries the index and `fix_attr` carries the attribute. The index then increases by one.
- R5: With a target index of 12, 13 or 14, a completed attribute gives no fixed write and no vertex data. Instead `invalid_wr` pulses for one cycle, in the cycle after the third word.
- R6: With index 15, a vertex is complete after `cfg_attr_num`+1 attributes. When the third vertex completes, `tri_valid` rises in the next cycle. Vertex k, attribute a is found at `tri_vertices[(k*16+a)*96 +: 96]`.
- R7: When a triangle is accepted with `cfg_prim_type` 0 or 3 (list), all three vertices are dropped. The next triangle needs three new vertices.
- R8: When a triangle is accepted with `cfg_prim_type` 1 (strip), the first vertex is dropped. The second and third vertices become vertex 0 and vertex 1, so the next triangle follows after one new vertex.
- R9: When a triangle is accepted with `cfg_prim_type` 2 (fan), vertex 0 is kept and the third vertex becomes vertex 1. The next triangle follows after one new vertex.
- R10: While `tri_valid` is 1 and `tri_ready` is 0, `tri_vertices` and `tri_valid` hold, and `wr_ready` is 0.
- R11: If an attribute reaches the immediate path while the attribute count is already at or above `cfg_attr_num`+1, `state_err` pulses for one cycle. The partial vertex is dropped and the vertex count is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted when high together with `wr_valid` |
| wr_is_index | input | 1 | 1: target-index write, 0: data word |
| wr_data | input | 32 | Write payload |
| cfg_attr_num | input | 4 | Attributes per immediate vertex, minus one |
| cfg_prim_type | input | 2 | 0/3 list, 1 strip, 2 fan |
| fix_we | output | 1 | Fixed-attribute write strobe |
| fix_slot | output | 4 | Fixed-attribute slot |
| fix_attr | output | 96 | Unpacked attribute |
| invalid_wr | output | 1 | Attribute sent to index 12 to 14 |
| state_err | output | 1 | Immediate-path count error |
| tri_valid | output | 1 | Triangle offered |
| tri_ready | input | 1 | Triangle taken |
| tri_vertices | output | 4608 | Three vertices of 16 attributes of 96 bits |

## Verification
The results fall due at fixed cycles:

- `fix_we`, `invalid_wr`, `state_err` and a rise of `tri_valid` all appear one cycle after the clock edge that accepts the third data word of an attribute.
- `wr_ready` falls in that same cycle.
- A vertex handover takes effect at the edge where `tri_valid` and `tri_ready` are both high.

The bench drives each write for exactly one accepting edge and returns on the following falling edge. It samples every pulse and the triangle contents there, so no pulse is missed and no stale value is read. Retention is checked by counting how many further vertices produce the next triangle, and by comparing its contents against the expected vertex tags.

// File: rtl/vattr_pkg.sv
package vattr_pkg;
  localparam int WORD_W    = 32;
  localparam int COMP_W    = 24;
  localparam int ATTR_W    = 4 * COMP_W;
  localparam int IDX_W     = 4;
  localparam int IMM_INDEX = 15;

  typedef logic [ATTR_W-1:0] attr_t;

  // Repack three words (arrival order w0, w1, w2) into four components
  function automatic attr_t unpack_attr(input logic [WORD_W-1:0] w0,
                                        input logic [WORD_W-1:0] w1,
                                        input logic [WORD_W-1:0] w2);
    logic [COMP_W-1:0] c0, c1, c2, c3;
    c0 = w2[23:0];
    c1 = {w1[15:0], w2[31:24]};
    c2 = {w0[7:0], w1[31:16]};
    c3 = w0[31:8];
    return {c3, c2, c1, c0};
  endfunction
endpackage

// File: rtl/vattr_word_collector.sv
module vattr_word_collector
  import vattr_pkg::*;
#(
  parameter int FIX_SLOTS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              is_index,
  input  logic [WORD_W-1:0] data,
  output logic              attr_fire,
  output attr_t             attr,
  output logic [IDX_W-1:0]  attr_idx
);
  logic [1:0]        wcnt;
  logic [WORD_W-1:0] w0_q, w1_q;
  logic [IDX_W-1:0]  idx_q;

  assign attr_fire = acc && !is_index && (wcnt == 2'd2);
  assign attr      = unpack_attr(w0_q, w1_q, data);
  assign attr_idx  = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt  <= '0;
      idx_q <= '0;
    end else if (acc && is_index) begin
      idx_q <= data[IDX_W-1:0];
      wcnt  <= '0;
    end else if (acc) begin
      if (wcnt == 2'd2) begin
        wcnt <= '0;
        if (32'(idx_q) < FIX_SLOTS) idx_q <= idx_q + 1'b1;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc && !is_index && wcnt == 2'd0) w0_q <= data;
    if (acc && !is_index && wcnt == 2'd1) w1_q <= data;
  end

  p_wcnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt != 2'd3);
  p_index_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_index) |=> (wcnt == 2'd0));
endmodule

// File: rtl/vattr_fixed_port.sv
module vattr_fixed_port
  import vattr_pkg::*;
#(
  parameter int FIX_SLOTS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             attr_fire,
  input  attr_t            attr,
  input  logic [IDX_W-1:0] attr_idx,
  output logic             fix_we,
  output logic [IDX_W-1:0] fix_slot,
  output attr_t            fix_attr,
  output logic             invalid_wr
);
  logic to_bank, to_void;
  assign to_bank = attr_fire && (32'(attr_idx) < FIX_SLOTS);
  assign to_void = attr_fire && (32'(attr_idx) >= FIX_SLOTS) && (32'(attr_idx) != IMM_INDEX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fix_we     <= 1'b0;
      invalid_wr <= 1'b0;
      fix_slot   <= '0;
      fix_attr   <= '0;
    end else begin
      fix_we     <= to_bank;
      invalid_wr <= to_void;
      if (to_bank) begin
        fix_slot <= attr_idx;
        fix_attr <= attr;
      end
    end
  end

  p_slot_in_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fix_we |-> (32'(fix_slot) < FIX_SLOTS));
  p_one_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fix_we, invalid_wr}));
endmodule

// File: rtl/vattr_vertex_gather.sv
module vattr_vertex_gather
  import vattr_pkg::*;
#(
  parameter int MAX_ATTRS = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          take,
  input  attr_t                         attr,
  input  logic [3:0]                    cfg_attr_num,
  input  logic [1:0]                    cfg_prim_type,
  input  logic                          tri_ready,
  output logic                          tri_valid,
  output logic [3*MAX_ATTRS*ATTR_W-1:0] tri_vertices,
  output logic                          state_err
);
  localparam int CNT_W = $clog2(MAX_ATTRS + 1);

  logic [CNT_W-1:0] acnt, need;
  logic [1:0]       vcnt;
  attr_t            cur [MAX_ATTRS];
  attr_t            vtx [3][MAX_ATTRS];
  logic             bad, done, handoff, keep_two;

  assign need     = CNT_W'(cfg_attr_num) + 1'b1;
  assign bad      = take && (acnt >= need);
  assign done     = take && !bad && ((acnt + 1'b1) == need);
  assign handoff  = tri_valid && tri_ready;
  assign keep_two = (cfg_prim_type == 2'd1) || (cfg_prim_type == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acnt      <= '0;
      vcnt      <= '0;
      tri_valid <= 1'b0;
      state_err <= 1'b0;
    end else begin
      state_err <= bad;
      if (bad) begin
        acnt <= '0;
      end else if (done) begin
        acnt <= '0;
        vcnt <= vcnt + 1'b1;
        if (vcnt == 2'd2) tri_valid <= 1'b1;
      end else if (take) begin
        acnt <= acnt + 1'b1;
      end
      if (handoff) begin
        tri_valid <= 1'b0;
        vcnt      <= keep_two ? 2'd2 : 2'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int a = 0; a < MAX_ATTRS; a++) begin
      if (take && !bad && CNT_W'(a) == acnt) cur[a] <= attr;
      for (int k = 0; k < 3; k++) begin
        if (done && vcnt == 2'(k))
          vtx[k][a] <= (CNT_W'(a) == acnt) ? attr : cur[a];
      end
      if (handoff && cfg_prim_type == 2'd1) begin
        vtx[0][a] <= vtx[1][a];
        vtx[1][a] <= vtx[2][a];
      end else if (handoff && cfg_prim_type == 2'd2) begin
        vtx[1][a] <= vtx[2][a];
      end
    end
  end

  for (genvar k = 0; k < 3; k++) begin : g_vert
    for (genvar a = 0; a < MAX_ATTRS; a++) begin : g_attr
      assign tri_vertices[(k*MAX_ATTRS+a)*ATTR_W +: ATTR_W] = vtx[k][a];
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_valid && !tri_ready) |=> (tri_valid && $stable(tri_vertices)));
  p_no_take_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && tri_valid));
  p_err_no_issue_r11: assert property (@(posedge clk) disable iff (!rst_n)
    state_err |-> !$rose(tri_valid));
  p_vcnt_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tri_valid |-> (vcnt == 2'd3));
endmodule

// File: rtl/vattr_assembler.sv
module vattr_assembler
  import vattr_pkg::*;
#(
  parameter int FIX_SLOTS = 12,
  parameter int MAX_ATTRS = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_valid,
  output logic                          wr_ready,
  input  logic                          wr_is_index,
  input  logic [31:0]                   wr_data,
  input  logic [3:0]                    cfg_attr_num,
  input  logic [1:0]                    cfg_prim_type,
  output logic                          fix_we,
  output logic [3:0]                    fix_slot,
  output logic [95:0]                   fix_attr,
  output logic                          invalid_wr,
  output logic                          state_err,
  output logic                          tri_valid,
  input  logic                          tri_ready,
  output logic [3*MAX_ATTRS*96-1:0]     tri_vertices
);
  logic             wr_acc, attr_fire, imm_take;
  attr_t            attr;
  logic [IDX_W-1:0] attr_idx;

  assign wr_ready = !tri_valid;
  assign wr_acc   = wr_valid && wr_ready;
  assign imm_take = attr_fire && (32'(attr_idx) == IMM_INDEX);

  vattr_word_collector #(.FIX_SLOTS(FIX_SLOTS)) u_collect (
    .clk, .rst_n, .acc(wr_acc), .is_index(wr_is_index), .data(wr_data),
    .attr_fire, .attr, .attr_idx
  );

  vattr_fixed_port #(.FIX_SLOTS(FIX_SLOTS)) u_fixed (
    .clk, .rst_n, .attr_fire, .attr, .attr_idx,
    .fix_we, .fix_slot, .fix_attr, .invalid_wr
  );

  vattr_vertex_gather #(.MAX_ATTRS(MAX_ATTRS)) u_gather (
    .clk, .rst_n, .take(imm_take), .attr, .cfg_attr_num, .cfg_prim_type,
    .tri_ready, .tri_valid, .tri_vertices, .state_err
  );

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tri_valid |-> !wr_ready);
  p_fixed_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fix_we |-> $past(attr_fire));
endmodule

// File: tb/vattr_assembler_bench.sv
module vattr_assembler_bench;
  localparam int NA = 16;
  localparam int TW = 3 * NA * 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_is_index = 1'b0, tri_ready = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0] cfg_attr_num = '0;
  logic [1:0] cfg_prim_type = '0;
  logic wr_ready, fix_we, invalid_wr, state_err, tri_valid;
  logic [3:0] fix_slot;
  logic [95:0] fix_attr;
  logic [TW-1:0] tri_vertices;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  vattr_assembler u_vattr_assembler (
    .clk, .rst_n, .wr_valid, .wr_ready, .wr_is_index, .wr_data,
    .cfg_attr_num, .cfg_prim_type, .fix_we, .fix_slot, .fix_attr,
    .invalid_wr, .state_err, .tri_valid, .tri_ready, .tri_vertices
  );

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wd(input int tag, input int a, input int j);
    return {4'(j + 1), 4'(a), 8'(tag), 8'(tag * 7 + a), 8'(8'h3C ^ 8'(j * 17))};
  endfunction

  // expected layout: the three words concatenated w0,w1,w2 (R3)
  function automatic logic [95:0] exp_attr(input int tag, input int a);
    return {wd(tag, a, 0), wd(tag, a, 1), wd(tag, a, 2)};
  endfunction

  task automatic wr(input logic is_idx, input logic [31:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_is_index = is_idx; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic send_attr(input int tag, input int a);
    for (int j = 0; j < 3; j++) wr(1'b0, wd(tag, a, j));
  endtask

  task automatic send_vtx(input int tag);
    for (int a = 0; a <= int'(cfg_attr_num); a++) send_attr(tag, a);
  endtask

  task automatic check_tri(input string req, input int t0, input int t1, input int t2);
    int tags[3];
    tags = '{t0, t1, t2};
    chk(req, 96'(tri_valid), 96'(1));
    for (int k = 0; k < 3; k++)
      for (int a = 0; a <= int'(cfg_attr_num); a++)
        chk(req, tri_vertices[(k*NA+a)*96 +: 96], exp_attr(tags[k], a));
  endtask

  task automatic release_tri();
    @(negedge clk); tri_ready = 1'b1;
    @(negedge clk); tri_ready = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tri_ready = 1'b0; wr_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 wr_ready", 96'(wr_ready), 96'(1));
    chk("R1 tri_valid", 96'(tri_valid), 96'(0));
    chk("R1 fix_we", 96'(fix_we), 96'(0));
    chk("R1 flags", 96'({invalid_wr, state_err}), 96'(0));
    send_attr(9, 0);   // index 0 after reset
    chk("R1 index zero", 96'({fix_we, fix_slot}), 96'({1'b1, 4'd0}));
  endtask

  task automatic t_fixed();
    do_reset();
    wr(1'b1, 32'hFFFF_FFF3);   // low bits select slot 3
    wr(1'b0, 32'hDEAD_BEEF);   // partial word, dropped by next index write
    wr(1'b1, 32'h0000_0005);
    send_attr(20, 0);
    chk("R2 slot", 96'({fix_we, fix_slot}), 96'({1'b1, 4'd5}));
    chk("R3 unpack", fix_attr, exp_attr(20, 0));
    send_attr(21, 1);
    chk("R4 increment", 96'({fix_we, fix_slot}), 96'({1'b1, 4'd6}));
    chk("R3 unpack2", fix_attr, exp_attr(21, 1));
    @(negedge clk);
    chk("R4 pulse one cycle", 96'(fix_we), 96'(0));
  endtask

  task automatic t_invalid();
    do_reset();
    wr(1'b1, 32'd11);
    send_attr(30, 0);
    chk("R4 last slot", 96'({fix_we, fix_slot}), 96'({1'b1, 4'd11}));
    send_attr(31, 0);   // index now 12
    chk("R5 no fixed write", 96'(fix_we), 96'(0));
    chk("R5 invalid flag", 96'(invalid_wr), 96'(1));
    wr(1'b1, 32'd14);
    send_attr(32, 0);
    chk("R5 invalid 14", 96'({invalid_wr, fix_we, tri_valid}), 96'(3'b100));
    @(negedge clk);
    chk("R5 pulse one cycle", 96'(invalid_wr), 96'(0));
  endtask

  task automatic t_list();
    do_reset();
    cfg_attr_num = 4'd1; cfg_prim_type = 2'd0;
    wr(1'b1, 32'd15);
    send_vtx(1); send_vtx(2);
    chk("R6 not yet", 96'(tri_valid), 96'(0));
    send_vtx(3);
    check_tri("R6 triangle", 1, 2, 3);
    chk("R6 no fixed write", 96'(fix_we), 96'(0));
    release_tri();
    chk("R7 released", 96'(tri_valid), 96'(0));
    cfg_prim_type = 2'd3;
    send_vtx(4); send_vtx(5);
    chk("R7 list drops all", 96'(tri_valid), 96'(0));
    send_vtx(6);
    check_tri("R7 second list", 4, 5, 6);
    release_tri();
    send_vtx(7); send_vtx(8);
    chk("R7 type3 drops all", 96'(tri_valid), 96'(0));
  endtask

  task automatic t_strip();
    do_reset();
    cfg_attr_num = 4'd0; cfg_prim_type = 2'd1;
    wr(1'b1, 32'd15);
    send_vtx(10); send_vtx(11); send_vtx(12);
    check_tri("R8 first", 10, 11, 12);
    release_tri();
    send_vtx(13);
    check_tri("R8 strip keeps two", 11, 12, 13);
    release_tri();
    send_vtx(14);
    check_tri("R8 strip again", 12, 13, 14);
  endtask

  task automatic t_fan();
    do_reset();
    cfg_attr_num = 4'd0; cfg_prim_type = 2'd2;
    wr(1'b1, 32'd15);
    send_vtx(40); send_vtx(41); send_vtx(42);
    check_tri("R9 first", 40, 41, 42);
    release_tri();
    send_vtx(43);
    check_tri("R9 fan keeps first", 40, 42, 43);
    release_tri();
    send_vtx(44);
    check_tri("R9 fan again", 40, 43, 44);
  endtask

  task automatic t_stall();
    do_reset();
    cfg_attr_num = 4'd0; cfg_prim_type = 2'd0;
    wr(1'b1, 32'd15);
    send_vtx(50); send_vtx(51); send_vtx(52);
    chk("R10 ready low", 96'(wr_ready), 96'(0));
    @(negedge clk);
    wr_valid = 1'b1; wr_is_index = 1'b1; wr_data = 32'd15;
    repeat (2) @(negedge clk);
    chk("R10 still low", 96'(wr_ready), 96'(0));
    check_tri("R10 held", 50, 51, 52);
    tri_ready = 1'b1;
    @(negedge clk);
    tri_ready = 1'b0;
    chk("R10 reopened", 96'({wr_ready, tri_valid}), 96'(2'b10));
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic t_state_err();
    do_reset();
    cfg_attr_num = 4'd2; cfg_prim_type = 2'd0;
    wr(1'b1, 32'd15);
    send_attr(60, 0); send_attr(60, 1);
    cfg_attr_num = 4'd0;
    send_attr(60, 2);
    chk("R11 error flag", 96'(state_err), 96'(1));
    chk("R11 no triangle", 96'(tri_valid), 96'(0));
    send_vtx(61); send_vtx(62);
    chk("R11 count kept", 96'(tri_valid), 96'(0));
    send_vtx(63);
    check_tri("R11 after error", 61, 62, 63);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_fixed();
    t_invalid();
    t_list();
    t_strip();
    t_fan();
    t_stall();
    t_state_err();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule